// File: doc/BRIEF.md
# Hot-Swap Bus Connect Controller

This block decides when the clock and data lines of a plug-in card may be joined to the same two lines on a live backplane. It watches the backplane's serial data and serial clock levels, an active-low enable and a supply-good flag. It raises its connect output only when a transfer cannot be in progress. That is the case after a stop condition, or after the bus has stayed released long enough. Because of this, joining the segments never corrupts a transfer that is already running.

After enabling, the block first waits through a fixed start-up interval. It then keeps waiting until the bus qualifies. Once joined, the link is held regardless of later bus traffic. Only removing the enable or losing supply breaks it, and that happens at once. A ready status output reports the joined state.

Both intervals are counted in clock cycles. For a 125 MHz clock, the defaults equal about 95 µs. The idle count may be set anywhere between the cycle equivalents of 60 µs and 175 µs. All inputs are expected to be synchronised already.

Top module: `hsbus_link_ctrl`

## Requirements
- R1: While reset is applied and after its release with the enable inactive, `link_on` and `ready` are 0.
- R2: When `en_n` is 1 or `pwr_ok` is 0, `link_on` and `ready` are 0 in that same cycle, with no clock edge needed, even if the link was up.
- R3: While `pwr_ok` is 0, the link never comes up, whatever the enable and bus do. Once `pwr_ok` returns to 1, qualification starts afresh.
- R4: After the enable becomes active, the link stays down until the start-up interval has run. That interval is STARTUP_CYCLES rising edges after the edge that first sees the enable.
- R5: With `sda` and `scl` both held at 1, `link_on` rises after rising edge number max(STARTUP_CYCLES, IDLE_CYCLES)+2. Edges are counted from the first edge that samples the enable active.
- R6: A stop condition is `sda` going from 0 to 1 while `scl` is 1 on both that sample and the previous one. Once start-up is done, a stop seen while qualifying brings the link up on the next edge.
- R7: A start condition cancels a pending stop. A start is `sda` going from 1 to 0 while `scl` is 1 on both samples. A 0 on either line restarts the idle count.
- R8: Once up, the link stays up through any bus activity for as long as `en_n` is 0 and `pwr_ok` is 1.
- R9: `ready` is 1 exactly when `link_on` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Active-low enable for the link |
| pwr_ok | input | 1 | Supply good; 0 forces the link down |
| sda | input | 1 | Backplane data level, synchronised |
| scl | input | 1 | Backplane clock level, synchronised |
| link_on | output | 1 | 1 joins the card segment to the backplane |
| ready | output | 1 | Status: 1 while the link is joined |

## Verification
The bench measures, to the cycle, how long the link takes to come up by the idle route and by the stop route. A design with an off-by-one counter, or one that skips the start-up wait after an early stop, shows up as a wrong latency.

Several sequences target the qualification logic. One places a start after a stop and checks that the link stays down. Another pulls the clock low briefly in the middle of the idle count and expects the full count to restart. A design that forgot the stop or failed to clear the count would connect early.

Traffic is also run on a live link, which would expose a design that drops the connection when the bus goes busy. Enable and supply are then removed between edges, which would expose a design that waits for a clock edge before dropping the link.

// File: rtl/hsbus_link_ctrl.sv
module hsbus_link_ctrl #(
  parameter int unsigned STARTUP_CYCLES = 11875,
  parameter int unsigned IDLE_CYCLES    = 11875
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_n,
  input  logic pwr_ok,
  input  logic sda,
  input  logic scl,
  output logic link_on,
  output logic ready
);
  localparam int unsigned SW = $clog2(STARTUP_CYCLES + 1);
  localparam int unsigned IW = $clog2(IDLE_CYCLES + 1);

  typedef enum logic [1:0] {ST_OFF, ST_QUAL, ST_ON} st_t;

  st_t           st;
  logic [SW-1:0] su_cnt;
  logic [IW-1:0] idle_cnt;
  logic          sda_q, scl_q, stop_seen;

  wire hold_off  = en_n | ~pwr_ok;
  wire scl_hi    = scl & scl_q;
  wire stop_ev   = scl_hi & sda & ~sda_q;
  wire start_ev  = scl_hi & ~sda & sda_q;
  wire su_done   = (su_cnt == SW'(STARTUP_CYCLES));
  wire idle_done = (idle_cnt == IW'(IDLE_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_OFF;
      su_cnt    <= '0;
      idle_cnt  <= '0;
      stop_seen <= 1'b0;
      sda_q     <= 1'b1;
      scl_q     <= 1'b1;
    end else begin
      sda_q <= sda;
      scl_q <= scl;
      if (hold_off) begin
        st        <= ST_OFF;
        su_cnt    <= '0;
        idle_cnt  <= '0;
        stop_seen <= 1'b0;
      end else begin
        case (st)
          ST_OFF: begin
            st        <= ST_QUAL;
            su_cnt    <= '0;
            idle_cnt  <= '0;
            stop_seen <= 1'b0;
          end
          ST_QUAL: begin
            if (!su_done) su_cnt <= su_cnt + SW'(1);
            if (sda && scl) begin
              if (!idle_done) idle_cnt <= idle_cnt + IW'(1);
            end else begin
              idle_cnt <= '0;
            end
            if (start_ev)     stop_seen <= 1'b0;
            else if (stop_ev) stop_seen <= 1'b1;
            if (su_done && (stop_seen || idle_done)) st <= ST_ON;
          end
          default: st <= st;
        endcase
      end
    end
  end

  assign link_on = (st == ST_ON) & ~hold_off;
  assign ready   = link_on;
endmodule

module hsbus_link_ctrl_chk #(
  parameter int unsigned STARTUP_CYCLES = 11875
) (
  input logic clk,
  input logic rst_n,
  input logic en_n,
  input logic pwr_ok,
  input logic link_on,
  input logic ready
);
  logic [31:0] en_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                en_cnt <= '0;
    else if (en_n || !pwr_ok)  en_cnt <= '0;
    else if (en_cnt != '1)     en_cnt <= en_cnt + 32'd1;
  end

  p_drop_on_disable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> !link_on);

  p_no_link_low_power_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> !ready);

  p_startup_elapsed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_on) |-> (en_cnt >= 32'(STARTUP_CYCLES)));

  p_link_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    link_on |=> (en_n || !pwr_ok || link_on));

  p_ready_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(!en_n && pwr_ok));
endmodule

bind hsbus_link_ctrl hsbus_link_ctrl_chk #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_n(en_n), .pwr_ok(pwr_ok),
  .link_on(link_on), .ready(ready)
);

// File: tb/hsbus_link_ctrl_bench.sv
module hsbus_link_ctrl_bench;
  localparam int S = 16;
  localparam int I = 60;

  logic clk = 0, rst_n = 0, en_n = 1, pwr_ok = 1, sda = 1, scl = 1;
  logic link_on, ready;
  int compared = 0, mismatched = 0;

  typedef struct { string tag; int exp; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  hsbus_link_ctrl #(.STARTUP_CYCLES(S), .IDLE_CYCLES(I)) u_hsbus_link_ctrl (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .pwr_ok(pwr_ok),
    .sda(sda), .scl(scl), .link_on(link_on), .ready(ready));

  task automatic expect_val(input string tag, input int exp);
    item_t it;
    it.tag = tag; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic observe(input int act);
    item_t it;
    compared++;
    if (sb.size() == 0) begin
      mismatched++;
      $display("FAIL scoreboard empty: actual %0d expected none", act);
    end else begin
      it = sb.pop_front();
      if (act != it.exp) begin
        mismatched++;
        $display("FAIL %s: actual %0d expected %0d", it.tag, act, it.exp);
      end
    end
  endtask

  task automatic wait_link(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (link_on) break;
    end
  endtask

  task automatic drop_link();
    @(negedge clk); en_n = 1; sda = 1; scl = 1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    while (sb.size() != 0) begin
      void'(sb.pop_front());
      mismatched++;
      $display("FAIL scoreboard: expected item never observed");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    expect_val("R1 link in reset", 0);  observe(link_on);
    rst_n = 1;
    repeat (3) @(negedge clk);
    expect_val("R1 ready after reset, disabled", 0); observe(ready);

    // R5: idle route, bus released throughout
    en_n = 0;
    wait_link(200, n);
    expect_val("R5 idle-route latency", ((S > I) ? S : I) + 2); observe(n);
    expect_val("R9 ready with link", 1); observe(ready);

    // R8: traffic including start/stop patterns while joined
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      if (k % 2 == 0) sda = ~sda; else scl = ~scl;
    end
    @(negedge clk); sda = 1; scl = 1;
    expect_val("R8 link held through traffic", 1); observe(link_on);

    // R2: enable removal drops link without an edge
    #1 en_n = 1; #1;
    expect_val("R2 link drop on enable", 0); observe(link_on);
    expect_val("R2 ready drop on enable", 0); observe(ready);

    // R6/R4: stop route, early stop must still wait for start-up
    @(negedge clk); sda = 0;
    @(negedge clk); en_n = 0;
    wait_link(5, n);
    expect_val("R4 no link before start-up", 0); observe(link_on);
    sda = 1;
    wait_link(100, n);
    expect_val("R6 stop-route remaining latency", S + 2 - 5); observe(n);

    // R7: start after stop cancels it
    drop_link();
    sda = 0;
    @(negedge clk); en_n = 0;
    repeat (3) @(negedge clk);
    sda = 1;
    repeat (2) @(negedge clk);
    sda = 0;
    wait_link(100, n);
    expect_val("R7 start cancels stop", 0); observe(link_on);
    sda = 1;
    wait_link(10, n);
    expect_val("R6 stop after start-up connects next edge", 2); observe(n);

    // R7: brief low on clock restarts idle count
    drop_link();
    en_n = 0;
    wait_link(30, n);
    expect_val("R7 not joined mid idle", 0); observe(link_on);
    scl = 0;
    wait_link(1, n);
    scl = 1;
    wait_link(200, n);
    expect_val("R7 idle restart latency", I + 1); observe(n);

    // R3: supply not good holds link down
    drop_link();
    pwr_ok = 0; en_n = 0;
    wait_link(150, n);
    expect_val("R3 no link while supply low", 0); observe(link_on);
    pwr_ok = 1;
    wait_link(200, n);
    expect_val("R3 qualification restarts after supply good", ((S > I) ? S : I) + 2); observe(n);
    #1 pwr_ok = 0; #1;
    expect_val("R2 link drop on supply loss", 0); observe(link_on);
    expect_val("R9 ready drop on supply loss", 0); observe(ready);

    finish_run();
  end
endmodule